// File: doc/BRIEF.md
# Scoreboard Issue and Hazard Controller

This block is the central hazard controller of a pipeline that issues instructions in program order but lets them read operands, finish and write results out of order. Each cycle it can take one decoded instruction. An instruction carries an operation class, a destination register and two source registers, and it arrives on a valid/ready handshake. The block assigns the instruction to a free functional unit of its class. It then tells each unit when to read its operands. It accepts a completion pulse from a unit when that unit's execution ends, and it grants the result write-back.

The block holds two tables. A per-unit table records the destination, the sources, the unit that produces each source and a ready flag for each source. A per-register table records which unit will write that register. The block stalls at three separate points, and it uses neither forwarding nor renaming:

- Issue stalls on a busy unit or on an output dependence (WAW).
- Operand read stalls on a true dependence (RAW).
- Write-back stalls on an anti-dependence (WAR).

The datapath, the register contents and the unit latencies are outside the block. Each unit appears only as a read grant, a completion pulse and a write-back grant.

Top module: `sb_ctrl`

## Requirements
- R1: After reset no unit is busy. `in_ready` is high for every class, and `issue_unit`, `rd_grant` and `wb_grant` are all zero.
- R2: Classes map to units as follows: class 0 goes to unit 0; class 1 goes to units 1..MUL_UNITS, taking the lowest-index free one; class 2 goes to unit MUL_UNITS+1; class 3 goes to unit MUL_UNITS+2. `in_ready` is low when no unit of the class is free. When `in_valid` and `in_ready` are both high, `issue_unit` is one-hot on the chosen unit in that same cycle.
- R3: `in_ready` is low while any issued instruction that has not yet written back targets `in_dst`. This holds even when that write-back is granted in the current cycle.
- R4: A source is pending at issue if an instruction that has not written back targets it. The exception is a source whose producer is granted write-back in the issue cycle; that source counts as ready. `rd_grant[u]` is asserted only when both sources of unit u are ready, and at the earliest one cycle after issue.
- R5: `rd_grant[u]` is asserted for exactly one cycle per instruction. Reads may occur in an order different from issue order.
- R6: `ex_done[u]` is accepted only in the cycles after unit u's read grant and before its completion has been recorded. At any other time it has no effect, so no write-back follows from it.
- R7: A unit that has completed is denied write-back while another unit has not yet read its operands and holds the destination register as a source already marked ready.
- R8: At most one `wb_grant` bit is set per cycle, and it goes to the lowest-index eligible unit.
- R9: A write-back frees the unit, which can accept an issue in the next cycle. It also clears the register's pending writer and marks ready every waiting source produced by that unit. Those sources can be granted a read in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Instruction can issue this cycle |
| in_class | input | 2 | Operation class (see R2) |
| in_dst | input | $clog2(NUM_REGS) | Destination register |
| in_src1 | input | $clog2(NUM_REGS) | First source register |
| in_src2 | input | $clog2(NUM_REGS) | Second source register |
| issue_unit | output | MUL_UNITS+3 | One-hot unit receiving the issued instruction |
| rd_grant | output | MUL_UNITS+3 | Per-unit operand read grant |
| ex_done | input | MUL_UNITS+3 | Per-unit execution completion pulse |
| wb_grant | output | MUL_UNITS+3 | Per-unit result write-back grant |

## Verification
The hardest condition to reach is a write-back held off by an anti-dependence. It needs a completed unit whose destination register is an unread, ready source of a younger instruction, and that younger instruction must be stuck waiting on its other source. The stimulus produces this with a phase that draws registers from only four names while long, random completion delays keep several units in flight. A second phase uses the full register range. A reference model counts how often WAR stalls, WAW stalls, contested write-backs and second-multiplier issues occur, and the bench requires each count to be nonzero.

// File: rtl/sb_ctrl.sv
module sb_ctrl #(
  parameter int NUM_REGS  = 32,
  parameter int MUL_UNITS = 2,
  localparam int NF = MUL_UNITS + 3,
  localparam int RW = $clog2(NUM_REGS),
  localparam int UW = $clog2(NF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_class,
  input  logic [RW-1:0] in_dst,
  input  logic [RW-1:0] in_src1,
  input  logic [RW-1:0] in_src2,
  output logic [NF-1:0] issue_unit,
  output logic [NF-1:0] rd_grant,
  input  logic [NF-1:0] ex_done,
  output logic [NF-1:0] wb_grant
);

  typedef enum logic [1:0] {IDLE, WAIT, EXEC, DONE} phase_t;

  phase_t        ph [NF];
  logic [RW-1:0] fi [NF];
  logic [RW-1:0] fj [NF];
  logic [RW-1:0] fk [NF];
  logic [UW-1:0] qj [NF];
  logic [UW-1:0] qk [NF];
  logic [NF-1:0] qj_v, qk_v, rj, rk;

  logic [NUM_REGS-1:0] rs_v;
  logic [UW-1:0]       rs_fu [NUM_REGS];

  logic          found, wb_any, issue, pj, pk;
  logic [UW-1:0] iu, wb_idx;
  logic [NF-1:0] war_ok;

  function automatic logic [1:0] cls_of(int u);
    if (u == 0) return 2'd0;
    else if (u <= MUL_UNITS) return 2'd1;
    else if (u == MUL_UNITS + 1) return 2'd2;
    else return 2'd3;
  endfunction

  always_comb begin
    found = 1'b0;
    iu = '0;
    for (int u = 0; u < NF; u++)
      if (!found && ph[u] == IDLE && cls_of(u) == in_class) begin
        found = 1'b1;
        iu = UW'(u);
      end
  end

  assign in_ready   = found && !rs_v[in_dst];
  assign issue      = in_valid && in_ready;
  assign issue_unit = issue ? (NF'(1) << iu) : '0;

  always_comb
    for (int u = 0; u < NF; u++)
      rd_grant[u] = (ph[u] == WAIT) && rj[u] && rk[u];

  always_comb begin
    for (int u = 0; u < NF; u++) begin
      war_ok[u] = (ph[u] == DONE);
      for (int v = 0; v < NF; v++)
        if (v != u && ph[v] == WAIT &&
            ((fj[v] == fi[u] && rj[v]) || (fk[v] == fi[u] && rk[v])))
          war_ok[u] = 1'b0;
    end
    wb_any = 1'b0;
    wb_idx = '0;
    for (int u = 0; u < NF; u++)
      if (!wb_any && war_ok[u]) begin
        wb_any = 1'b1;
        wb_idx = UW'(u);
      end
  end

  assign wb_grant = wb_any ? (NF'(1) << wb_idx) : '0;
  assign pj = rs_v[in_src1] && !(wb_any && rs_fu[in_src1] == wb_idx);
  assign pk = rs_v[in_src2] && !(wb_any && rs_fu[in_src2] == wb_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_v <= '0;
      qj_v <= '0;
      qk_v <= '0;
      rj   <= '0;
      rk   <= '0;
      for (int u = 0; u < NF; u++) ph[u] <= IDLE;
    end else begin
      for (int u = 0; u < NF; u++) begin
        case (ph[u])
          WAIT: if (rj[u] && rk[u]) begin
            ph[u] <= EXEC;
            rj[u] <= 1'b0;
            rk[u] <= 1'b0;
          end
          EXEC: if (ex_done[u]) ph[u] <= DONE;
          DONE: if (wb_any && wb_idx == UW'(u)) ph[u] <= IDLE;
          default: ;
        endcase
        if (wb_any && ph[u] == WAIT && qj_v[u] && qj[u] == wb_idx) begin
          rj[u]   <= 1'b1;
          qj_v[u] <= 1'b0;
        end
        if (wb_any && ph[u] == WAIT && qk_v[u] && qk[u] == wb_idx) begin
          rk[u]   <= 1'b1;
          qk_v[u] <= 1'b0;
        end
      end
      if (wb_any) rs_v[fi[wb_idx]] <= 1'b0;
      if (issue) begin
        ph[iu]   <= WAIT;
        fi[iu]   <= in_dst;
        fj[iu]   <= in_src1;
        fk[iu]   <= in_src2;
        qj[iu]   <= rs_fu[in_src1];
        qk[iu]   <= rs_fu[in_src2];
        qj_v[iu] <= pj;
        qk_v[iu] <= pk;
        rj[iu]   <= !pj;
        rk[iu]   <= !pk;
        rs_v[in_dst]  <= 1'b1;
        rs_fu[in_dst] <= iu;
      end
    end
  end

endmodule

// File: rtl/sb_ctrl_chk.sv
module sb_ctrl_chk #(
  parameter int NF = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [NF-1:0] issue_unit,
  input logic [NF-1:0] rd_grant,
  input logic [NF-1:0] wb_grant
);

  p_onehot_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wb_grant));

  p_issue_hs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_unit) && ((issue_unit != '0) == (in_valid && in_ready)));

  for (genvar u = 0; u < NF; u++) begin : g_unit
    p_rd_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_grant[u] |=> !rd_grant[u]);

    p_wb_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wb_grant[u] |=> !rd_grant[u] && !wb_grant[u]);

    p_rd_not_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_grant[u] |-> !wb_grant[u]);

    p_issue_no_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      issue_unit[u] |-> !rd_grant[u] && !wb_grant[u]);
  end

endmodule

bind sb_ctrl sb_ctrl_chk #(.NF(MUL_UNITS + 3)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .issue_unit(issue_unit), .rd_grant(rd_grant), .wb_grant(wb_grant)
);

// File: tb/sb_ctrl_test.sv
module sb_ctrl_test;
  localparam int NR = 32;
  localparam int MU = 2;
  localparam int NF = MU + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_class = '0;
  logic [4:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [NF-1:0] issue_unit, rd_grant, wb_grant;
  logic [NF-1:0] ex_done = '0;

  sb_ctrl #(.NUM_REGS(NR), .MUL_UNITS(MU)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .issue_unit(issue_unit), .rd_grant(rd_grant), .ex_done(ex_done),
    .wb_grant(wb_grant)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  int war_seen = 0, waw_seen = 0, multi_seen = 0, mul2_seen = 0;

  // model: phase 0 idle,1 waiting,2 executing,3 completed; producer -1 = ready
  int ph[NF], fi[NF], fj[NF], fk[NF], wj[NF], wk[NF];
  int regw[NR];

  function automatic int cls(int u);
    if (u == 0) return 0;
    if (u <= MU) return 1;
    if (u == MU + 1) return 2;
    return 3;
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_step();
    int nu = -1, w = -1, cand = 0, pj, pk;
    bit blk;
    logic [NF-1:0] e_rd = '0, e_iss = '0, e_wb = '0;
    bit e_ready;
    for (int u = 0; u < NF; u++)
      if (nu < 0 && ph[u] == 0 && cls(u) == int'(in_class)) nu = u;
    e_ready = (nu >= 0) && (regw[in_dst] < 0);
    if (in_valid && nu >= 0 && regw[in_dst] >= 0) waw_seen++;
    if (in_valid && e_ready) e_iss[nu] = 1'b1;
    for (int u = 0; u < NF; u++)
      e_rd[u] = (ph[u] == 1 && wj[u] < 0 && wk[u] < 0);
    for (int u = 0; u < NF; u++)
      if (ph[u] == 3) begin
        blk = 0;
        for (int v = 0; v < NF; v++)
          if (v != u && ph[v] == 1 &&
              ((fj[v] == fi[u] && wj[v] < 0) || (fk[v] == fi[u] && wk[v] < 0)))
            blk = 1;
        if (blk) war_seen++;
        else begin
          cand++;
          if (w < 0) w = u;
        end
      end
    if (cand > 1) multi_seen++;
    if (w >= 0) e_wb[w] = 1'b1;

    chk("R2/R3 in_ready", int'(in_ready), int'(e_ready));
    chk("R2 issue_unit", int'(issue_unit), int'(e_iss));
    chk("R4/R5/R9 rd_grant", int'(rd_grant), int'(e_rd));
    chk("R6/R7/R8 wb_grant", int'(wb_grant), int'(e_wb));

    pj = regw[in_src1];
    pk = regw[in_src2];
    if (pj == w) pj = -1;
    if (pk == w) pk = -1;
    for (int u = 0; u < NF; u++)
      if (e_rd[u]) ph[u] = 2;
      else if (ph[u] == 2 && ex_done[u]) ph[u] = 3;
    if (w >= 0) begin
      ph[w] = 0;
      regw[fi[w]] = -1;
      for (int v = 0; v < NF; v++) begin
        if (wj[v] == w) wj[v] = -1;
        if (wk[v] == w) wk[v] = -1;
      end
    end
    if (in_valid && e_ready) begin
      if (nu == 2) mul2_seen++;
      ph[nu] = 1; fi[nu] = int'(in_dst); fj[nu] = int'(in_src1);
      fk[nu] = int'(in_src2); wj[nu] = pj; wk[nu] = pk;
      regw[in_dst] = nu;
    end
  endtask

  task automatic run_phase(int cycles, int rmax);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      in_valid = ($urandom_range(0, 9) < 7);
      in_class = 2'($urandom_range(0, 3));
      in_dst   = 5'($urandom_range(0, rmax));
      in_src1  = 5'($urandom_range(0, rmax));
      in_src2  = 5'($urandom_range(0, rmax));
      for (int u = 0; u < NF; u++) ex_done[u] = ($urandom_range(0, 3) == 0);
      #1;
      model_step();
    end
  endtask

  initial begin
    for (int u = 0; u < NF; u++) begin
      ph[u] = 0; fi[u] = 0; fj[u] = 0; fk[u] = 0; wj[u] = -1; wk[u] = -1;
    end
    for (int r = 0; r < NR; r++) regw[r] = -1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      in_class = 2'(k);
      #1;
      chk("R1 reset in_ready", int'(in_ready), 1);
    end
    chk("R1 reset issue", int'(issue_unit), 0);
    chk("R1 reset rd", int'(rd_grant), 0);
    chk("R1 reset wb", int'(wb_grant), 0);
    rst_n = 1'b1;
    run_phase(4000, 3);
    run_phase(4000, 31);
    chk("R7 war stall seen", int'(war_seen > 0), 1);
    chk("R3 waw stall seen", int'(waw_seen > 0), 1);
    chk("R8 contested wb seen", int'(multi_seen > 0), 1);
    chk("R2 second multiplier used", int'(mul2_seen > 0), 1);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule